// File: doc/BRIEF.md
# Decode-Stage Register File with Result Bypass

This block holds the architectural integer registers of a five-stage pipeline and sits in the decode stage. Each cycle it resolves two source operands. Results can still be in flight in the execute, memory/IO and writeback stages. When one of those stages is about to write a register that decode is reading, the in-flight value replaces the stored one. An instruction therefore never waits for its producer to retire before it can use the result.

The file has one write port, driven by the writeback stage, which commits on the rising clock edge. Both reads are combinational. Register 0 is hard-wired to zero.

There is no clocked control sequence. Each read port picks one of three sources:
- **zero**, when the index is 0;
- **forward**, when a later stage matches the index;
- **file**, otherwise.

The choice between them is a combinational decision on the current inputs.

Top module: `fwd_regfile`

## Requirements
- R1: After reset is released, every register index reads as zero on both ports while no stage is forwarding.
- R2: Index 0 reads as zero on both ports at all times. A stage that targets index 0 is never forwarded, and a writeback to index 0 leaves it reading zero afterwards.
- R3: A writeback with `wb_we` = 1 and a non-zero `wb_dst` stores `wb_val` at the rising clock edge. Later reads of that index return the stored value when no stage matches it.
- R4: A writeback to an index that is read in the same cycle is visible to that read before the clock edge, when execute and memory/IO do not match.
- R5: When the execute stage has `ex_we` = 1 and `ex_dst` equals a non-zero read index, that port returns `ex_val`, whatever memory/IO and writeback hold.
- R6: When execute does not match and memory/IO has `mem_we` = 1 with `mem_dst` equal to a non-zero read index, that port returns `mem_val` in preference to writeback.
- R7: A stage whose write-enable is 0 is not forwarded, even when its destination equals the read index.
- R8: The two read ports resolve independently: different indices return their own values in the same cycle.
- R9: With no matching stage, a read returns the last value written to that index since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset that clears all registers |
| rd_a_idx | input | 5 | Index of first source operand |
| rd_b_idx | input | 5 | Index of second source operand |
| ex_we | input | 1 | Execute stage will write a register |
| ex_dst | input | 5 | Execute stage destination index |
| ex_val | input | 32 | Execute stage result |
| mem_we | input | 1 | Memory/IO stage will write a register |
| mem_dst | input | 5 | Memory/IO stage destination index |
| mem_val | input | 32 | Memory/IO stage result |
| wb_we | input | 1 | Writeback stage writes a register this cycle |
| wb_dst | input | 5 | Writeback destination index |
| wb_val | input | 32 | Writeback result |
| op_a | output | 32 | Resolved first operand |
| op_b | output | 32 | Resolved second operand |

## Verification
The writeback commit and a decode read of the same register fall in the same cycle. So do several stages that all claim one index. The bench provokes both:
- **Directed cases** aim all three stages, or only some of them, at one register while writeback also targets it.
- **Random stimulus** draws indices from a narrow range so that collisions between reads, forwards and writes are frequent.

Each operand is judged before the edge against a bench model. The model applies youngest-first selection over the stored values, and the stored values are updated only after the edge.

// File: rtl/fwd_regfile_pkg.sv
package fwd_regfile_pkg;

    // Source picked by one read port
    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_FILE = 2'd1,
        SRC_FWD  = 2'd2
    } rd_src_e;

    // Stage slots in bypass vectors, youngest first
    localparam int STG_EX  = 0;
    localparam int STG_MEM = 1;
    localparam int STG_WB  = 2;
    localparam int N_STAGE = 3;

endpackage

// File: rtl/fwd_regfile_store.sv
module fwd_regfile_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    parameter int N_RD  = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [N_RD-1:0][AW-1:0]  raddr,
    output logic [N_RD-1:0][DW-1:0]  rdata
);

    logic [DEPTH-1:0][DW-1:0] regs;

    // Entry 0 is a constant zero
    assign regs[0] = '0;

    for (genvar i = 1; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && (waddr == AW'(i))) begin
                regs[i] <= wdata;
            end
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        assign rdata[p] = regs[raddr[p]];
    end

endmodule

// File: rtl/fwd_regfile_bypass.sv
module fwd_regfile_bypass
    import fwd_regfile_pkg::*;
#(
    parameter int AW     = 5,
    parameter int DW     = 32,
    parameter int NSTAGE = N_STAGE
) (
    input  logic [AW-1:0]              idx,
    input  logic [DW-1:0]              file_val,
    input  logic [NSTAGE-1:0]          st_we,
    input  logic [NSTAGE-1:0][AW-1:0]  st_dst,
    input  logic [NSTAGE-1:0][DW-1:0]  st_val,
    output logic [DW-1:0]              operand
);

    logic [NSTAGE-1:0] hit;
    logic [DW-1:0]     fwd_val;
    rd_src_e           src;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_hit
        assign hit[s] = st_we[s] && (st_dst[s] != '0) && (st_dst[s] == idx);
    end

    // Oldest first, so that a younger hit overrides it
    always_comb begin
        fwd_val = '0;
        for (int s = NSTAGE - 1; s >= 0; s--) begin
            if (hit[s]) fwd_val = st_val[s];
        end
    end

    always_comb begin
        if (idx == '0)  src = SRC_ZERO;
        else if (|hit)  src = SRC_FWD;
        else            src = SRC_FILE;
    end

    always_comb begin
        unique case (src)
            SRC_ZERO: operand = '0;
            SRC_FWD:  operand = fwd_val;
            SRC_FILE: operand = file_val;
            default:  operand = '0;
        endcase
    end

endmodule

// File: rtl/fwd_regfile.sv
module fwd_regfile
    import fwd_regfile_pkg::*;
#(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    input  logic          ex_we,
    input  logic [AW-1:0] ex_dst,
    input  logic [DW-1:0] ex_val,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_dst,
    input  logic [DW-1:0] mem_val,
    input  logic          wb_we,
    input  logic [AW-1:0] wb_dst,
    input  logic [DW-1:0] wb_val,
    output logic [DW-1:0] op_a,
    output logic [DW-1:0] op_b
);

    localparam int N_RD = 2;

    logic [N_RD-1:0][AW-1:0]    rd_idx;
    logic [N_RD-1:0][DW-1:0]    file_val;
    logic [N_RD-1:0][DW-1:0]    resolved;
    logic [N_STAGE-1:0]         st_we;
    logic [N_STAGE-1:0][AW-1:0] st_dst;
    logic [N_STAGE-1:0][DW-1:0] st_val;

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    assign st_we[STG_EX]   = ex_we;
    assign st_dst[STG_EX]  = ex_dst;
    assign st_val[STG_EX]  = ex_val;
    assign st_we[STG_MEM]  = mem_we;
    assign st_dst[STG_MEM] = mem_dst;
    assign st_val[STG_MEM] = mem_val;
    assign st_we[STG_WB]   = wb_we;
    assign st_dst[STG_WB]  = wb_dst;
    assign st_val[STG_WB]  = wb_val;

    fwd_regfile_store #(
        .DEPTH (NREG),
        .DW    (DW),
        .N_RD  (N_RD)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_we),
        .waddr (wb_dst),
        .wdata (wb_val),
        .raddr (rd_idx),
        .rdata (file_val)
    );

    for (genvar p = 0; p < N_RD; p++) begin : g_port
        fwd_regfile_bypass #(
            .AW     (AW),
            .DW     (DW),
            .NSTAGE (N_STAGE)
        ) u_byp (
            .idx      (rd_idx[p]),
            .file_val (file_val[p]),
            .st_we    (st_we),
            .st_dst   (st_dst),
            .st_val   (st_val),
            .operand  (resolved[p])
        );
    end

    assign op_a = resolved[0];
    assign op_b = resolved[1];

endmodule

// File: rtl/fwd_regfile_chk.sv
module fwd_regfile_chk #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] rd_a_idx,
    input logic [AW-1:0] rd_b_idx,
    input logic          ex_we,
    input logic [AW-1:0] ex_dst,
    input logic [DW-1:0] ex_val,
    input logic          mem_we,
    input logic [AW-1:0] mem_dst,
    input logic [DW-1:0] mem_val,
    input logic          wb_we,
    input logic [AW-1:0] wb_dst,
    input logic [DW-1:0] wb_val,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b
);

    logic ex_a, mem_a, wb_a, ex_b;

    assign ex_a  = ex_we  && (ex_dst  == rd_a_idx) && (rd_a_idx != '0);
    assign mem_a = mem_we && (mem_dst == rd_a_idx) && (rd_a_idx != '0);
    assign wb_a  = wb_we  && (wb_dst  == rd_a_idx) && (rd_a_idx != '0);
    assign ex_b  = ex_we  && (ex_dst  == rd_b_idx) && (rd_b_idx != '0);

    AST_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == '0) |-> (op_a == '0));                          // R2
    AST_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == '0) |-> (op_b == '0));                          // R2
    AST_EX_FIRST_A: assert property (@(posedge clk) disable iff (!rst_n)
        ex_a |-> (op_a == ex_val));                                  // R5
    AST_EX_FIRST_B: assert property (@(posedge clk) disable iff (!rst_n)
        ex_b |-> (op_b == ex_val));                                  // R5
    AST_MEM_OVER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_a && mem_a) |-> (op_a == mem_val));                     // R6
    AST_WB_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_a && !mem_a && wb_a) |-> (op_a == wb_val));             // R4
    AST_WB_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wb_we) && ($past(wb_dst) != '0)
         && (rd_a_idx == $past(wb_dst)) && !ex_a && !mem_a && !wb_a)
        |-> (op_a == $past(wb_val)));                                // R3

endmodule

bind fwd_regfile fwd_regfile_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/fwd_regfile_test.sv
`timescale 1ns/1ps
module fwd_regfile_test;

    localparam int AW = 5;
    localparam int DW = 32;
    localparam int NR = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] rd_a_idx = '0, rd_b_idx = '0;
    logic          ex_we = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic [AW-1:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
    logic [DW-1:0] ex_val = '0, mem_val = '0, wb_val = '0;
    logic [DW-1:0] op_a, op_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] model [NR];

    always #4 clk = ~clk;

    fwd_regfile uut (.*);

    function automatic logic [DW-1:0] expect_op(input logic [AW-1:0] idx);
        if (idx == '0)                    return '0;
        if (ex_we  && ex_dst  == idx)     return ex_val;
        if (mem_we && mem_dst == idx)     return mem_val;
        if (wb_we  && wb_dst  == idx)     return wb_val;
        return model[idx];
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Inputs already set after a negedge: check, cross the edge, update model
    task automatic step(input string req);
        #2;
        chk(req, op_a, expect_op(rd_a_idx));
        chk(req, op_b, expect_op(rd_b_idx));
        @(posedge clk);
        if (wb_we && wb_dst != '0) model[wb_dst] = wb_val;
        @(negedge clk);
    endtask

    task automatic quiet();
        ex_we = 0; mem_we = 0; wb_we = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state on every index
        for (int i = 0; i < NR; i++) begin
            rd_a_idx = AW'(i); rd_b_idx = AW'(NR - 1 - i);
            step("R1");
        end

        // R3 / R9: write then read back
        wb_we = 1; wb_dst = 5; wb_val = 32'hCAFE_0005;
        step("R4");
        quiet(); rd_a_idx = 5; rd_b_idx = 6;
        step("R3");
        chk("R3", op_a, 32'hCAFE_0005);

        // R4: same-cycle writeback visible
        wb_we = 1; wb_dst = 9; wb_val = 32'h1111_0009; rd_a_idx = 9; rd_b_idx = 9;
        #2 chk("R4", op_a, 32'h1111_0009);
        #0 step("R4");

        // R5: all three stages claim index 7
        ex_we = 1; ex_dst = 7; ex_val = 32'hE0E0_0007;
        mem_we = 1; mem_dst = 7; mem_val = 32'hA0A0_0007;
        wb_we = 1; wb_dst = 7; wb_val = 32'hB0B0_0007;
        rd_a_idx = 7; rd_b_idx = 7;
        #2 chk("R5", op_a, 32'hE0E0_0007);
        #0 step("R5");

        // R6: memory/IO over writeback
        ex_we = 0; mem_we = 1; mem_dst = 7; mem_val = 32'h3333_0007;
        wb_we = 1; wb_dst = 7; wb_val = 32'h4444_0007;
        #2 chk("R6", op_a, 32'h3333_0007);
        #0 step("R6");

        // R7: disabled stages with matching destinations are ignored
        quiet(); ex_dst = 7; mem_dst = 7; wb_dst = 7;
        ex_val = 32'hDEAD_0001; mem_val = 32'hDEAD_0002; wb_val = 32'hDEAD_0003;
        #2 chk("R7", op_a, 32'h4444_0007);
        #0 step("R7");

        // R2: stages aiming at index 0 and a write to it
        ex_we = 1; ex_dst = 0; mem_we = 1; mem_dst = 0; wb_we = 1; wb_dst = 0;
        wb_val = 32'hFFFF_FFFF; rd_a_idx = 0; rd_b_idx = 0;
        step("R2");
        quiet();
        #2 chk("R2", op_a, '0);
        chk("R2", op_b, '0);
        #0 step("R2");

        // R8: ports independent, one forwarded, one from file
        ex_we = 1; ex_dst = 5; ex_val = 32'h5555_AAAA; rd_a_idx = 5; rd_b_idx = 9;
        #2 chk("R8", op_a, 32'h5555_AAAA);
        chk("R8", op_b, 32'h1111_0009);
        #0 step("R8");
        quiet();

        // R9 / R5 / R6 / R4: constrained random with narrow indices
        for (int n = 0; n < 3000; n++) begin
            rd_a_idx = AW'($urandom % 6); rd_b_idx = AW'($urandom % 6);
            ex_we = 1'($urandom);  ex_dst = AW'($urandom % 6);  ex_val = $urandom;
            mem_we = 1'($urandom); mem_dst = AW'($urandom % 6); mem_val = $urandom;
            wb_we = 1'($urandom);  wb_dst = AW'($urandom % 6);  wb_val = $urandom;
            if (n % 50 == 0) begin
                rd_a_idx = AW'($urandom); rd_b_idx = AW'($urandom);
            end
            step("R9");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule